// File: doc/BRIEF.md
# Ordered Request Retry Queue

This block sits between a set of translation engines and two downstream memory request ports. One is a main port that carries finished, translated transactions. The other is an optional walk port that carries the table fetches made while a translation is in progress. Each incoming request carries a kind bit: intermediate (a walk fetch) or final (the translated transaction). It also carries an identifier so that its ordering can be observed.

When a request's port has nothing queued, the request is shown on that port in the same cycle and goes out at once if the port accepts it. Otherwise the request joins that port's in-order retry queue. A queue is replayed from its head only after its port pulses a retry strobe. Replay stops at the first entry the port refuses again, and the remaining entries wait for the next strobe. Progress that frees a transaction slot raises a registered one-cycle retry pulse. This pulse tells every upstream port it may present new work.

When no walk port is fitted (`walk_port_en_i` low), intermediate requests travel through the main port with the same queueing rules as final requests. They keep their kind on `main_final_o`.

Top module: `ordered_retry_queue`

## Requirements
- R1: While `rst_ni` is low and just after it is released, both queues are empty, `main_valid_o`, `walk_valid_o` and `up_retry_o` are 0, and `req_ready_o` is 1.
- R2: A request whose target queue is empty is shown on its target port in the same cycle. It leaves the block in that cycle if the port's ready is high.
- R3: A request that is refused while its queue is empty is appended to that queue. So is a request that arrives while its queue already holds entries. A port whose queue holds entries shows nothing unless it is draining.
- R4: Draining starts in a cycle where the port's retry strobe is high and its queue is not empty. The head is shown in that cycle. Each accepted head is followed in the next cycle by the next entry, in arrival order. Draining stops at the first refusal, or after the entry that was the last one left is accepted; the remaining entries wait for another strobe.
- R5: With `walk_port_en_i` = 1, a request with `req_final_i` = 0 (intermediate) is routed to the walk port and a request with `req_final_i` = 1 (final) is routed to the main port. With `walk_port_en_i` = 0, every request is routed to the main port and its kind appears unchanged on `main_final_o`.
- R6: The walk port only ever carries intermediate requests, so its queue never holds a final one.
- R7: `up_retry_o` is high for one cycle, in the cycle after any of these: a request is accepted directly on either port, or a final request is accepted from the head of the main queue. Accepting an intermediate request from either queue does not raise it. Several such events in one cycle give a single high cycle.
- R8: When the queue of a request's target port holds DEPTH entries, `req_ready_o` is 0, and that request is neither shown nor stored.
- R9: A retry strobe on a port whose queue is empty shows nothing on that port and does not change what the block does later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| walk_port_en_i | input | 1 | High when a walk port is fitted; held steady while the queues are non-empty |
| req_valid_i | input | 1 | Upstream request valid |
| req_final_i | input | 1 | Request kind: 1 final, 0 intermediate |
| req_id_i | input | ID_W | Request identifier |
| req_ready_o | output | 1 | Request taken this cycle (target queue not full) |
| main_valid_o | output | 1 | Main port request valid |
| main_final_o | output | 1 | Kind of the request on the main port |
| main_id_o | output | ID_W | Identifier on the main port |
| main_ready_i | input | 1 | Main port accepts in this cycle |
| main_retry_i | input | 1 | Main port retry strobe |
| walk_valid_o | output | 1 | Walk port request valid |
| walk_id_o | output | ID_W | Identifier on the walk port |
| walk_ready_i | input | 1 | Walk port accepts in this cycle |
| walk_retry_i | input | 1 | Walk port retry strobe |
| up_retry_o | output | 1 | Registered retry pulse sent to all upstream ports |

## Verification
The bench keeps an ideal queue per port and predicts every output on every cycle. It aims at several specific failure modes:
- A queue that overtakes itself, showing a new request ahead of older queued entries, shows up as a wrong identifier on the port.
- Draining that carries on past a refusal, or that restarts without a strobe, shows up as valid with no retry in flight.
- A pulse raised when an intermediate entry leaves a queue, or one missing after a direct accept, gives an `up_retry_o` mismatch.
- Long runs with a rarely-ready port fill the queues. These runs catch a `req_ready_o` that ignores fullness.
- Idle strobes on empty queues and a phase with the walk port absent cover the fallback routing and the no-effect strobe.

// File: rtl/orq_pkg.sv
package orq_pkg;
  typedef enum logic {
    LANE_WALK = 1'b0,
    LANE_MAIN = 1'b1
  } lane_e;
endpackage

// File: rtl/orq_fifo.sv
module orq_fifo #(
  parameter int W     = 5,
  parameter int DEPTH = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_i,
  input  logic                         pop_i,
  input  logic [W-1:0]                 data_i,
  output logic [W-1:0]                 head_o,
  output logic [$clog2(DEPTH+1)-1:0]   cnt_o,
  output logic                         empty_o,
  output logic                         full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_q] <= data_i;
  end

  assign head_o  = mem[rd_q];
  assign cnt_o   = cnt_q;
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/orq_lane.sv
module orq_lane #(
  parameter int            ID_W  = 4,
  parameter int            DEPTH = 4,
  parameter orq_pkg::lane_e KIND = orq_pkg::LANE_MAIN
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  input  logic            in_final_i,
  input  logic [ID_W-1:0] in_id_i,
  input  logic            port_ready_i,
  input  logic            port_retry_i,
  output logic            port_valid_o,
  output logic            port_final_o,
  output logic [ID_W-1:0] port_id_o,
  output logic            full_o,
  output logic            kick_o
);
  localparam int W     = ID_W + 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     head;
  logic [CNT_W-1:0] cnt;
  logic             empty, push, pop, direct, draining, drain_q;

  orq_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .pop_i   (pop),
    .data_i  ({in_final_i, in_id_i}),
    .head_o  (head),
    .cnt_o   (cnt),
    .empty_o (empty),
    .full_o  (full_o)
  );

  // head is shown only while a strobe-started drain is running
  assign draining = (drain_q | port_retry_i) & ~empty;
  assign direct   = empty & in_valid_i & port_ready_i;
  assign pop      = draining & port_ready_i;
  assign push     = in_valid_i & ~direct;

  assign port_valid_o = draining | (empty & in_valid_i);
  assign {port_final_o, port_id_o} = draining ? head : {in_final_i, in_id_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drain_q <= 1'b0;
    else         drain_q <= pop & (cnt > CNT_W'(1));
  end

  generate
    if (KIND == orq_pkg::LANE_MAIN) begin : g_main_kick
      assign kick_o = direct | (pop & head[W-1]);
    end else begin : g_walk_kick
      assign kick_o = direct;
    end
  endgenerate
endmodule

// File: rtl/ordered_retry_queue.sv
module ordered_retry_queue #(
  parameter int ID_W  = 4,
  parameter int DEPTH = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            walk_port_en_i,
  input  logic            req_valid_i,
  input  logic            req_final_i,
  input  logic [ID_W-1:0] req_id_i,
  output logic            req_ready_o,
  output logic            main_valid_o,
  output logic            main_final_o,
  output logic [ID_W-1:0] main_id_o,
  input  logic            main_ready_i,
  input  logic            main_retry_i,
  output logic            walk_valid_o,
  output logic [ID_W-1:0] walk_id_o,
  input  logic            walk_ready_i,
  input  logic            walk_retry_i,
  output logic            up_retry_o
);
  logic to_walk, main_full, walk_full, main_in, walk_in;
  logic main_kick, walk_kick, walk_final;

  assign to_walk     = walk_port_en_i & ~req_final_i;
  assign req_ready_o = to_walk ? ~walk_full : ~main_full;
  assign main_in     = req_valid_i & ~to_walk & ~main_full;
  assign walk_in     = req_valid_i &  to_walk & ~walk_full;

  orq_lane #(.ID_W(ID_W), .DEPTH(DEPTH), .KIND(orq_pkg::LANE_MAIN)) u_main (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .in_valid_i   (main_in),
    .in_final_i   (req_final_i),
    .in_id_i      (req_id_i),
    .port_ready_i (main_ready_i),
    .port_retry_i (main_retry_i),
    .port_valid_o (main_valid_o),
    .port_final_o (main_final_o),
    .port_id_o    (main_id_o),
    .full_o       (main_full),
    .kick_o       (main_kick)
  );

  orq_lane #(.ID_W(ID_W), .DEPTH(DEPTH), .KIND(orq_pkg::LANE_WALK)) u_walk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .in_valid_i   (walk_in),
    .in_final_i   (req_final_i),
    .in_id_i      (req_id_i),
    .port_ready_i (walk_ready_i),
    .port_retry_i (walk_retry_i),
    .port_valid_o (walk_valid_o),
    .port_final_o (walk_final),
    .port_id_o    (walk_id_o),
    .full_o       (walk_full),
    .kick_o       (walk_kick)
  );

  // merged triggers -> single registered pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) up_retry_o <= 1'b0;
    else         up_retry_o <= main_kick | walk_kick;
  end
endmodule

// File: rtl/orq_checker.sv
module orq_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic walk_port_en_i,
  input logic main_valid_o,
  input logic main_final_o,
  input logic main_ready_i,
  input logic main_retry_i,
  input logic walk_valid_o,
  input logic walk_final,
  input logic walk_ready_i,
  input logic walk_retry_i,
  input logic up_retry_o
);
  p_pulse_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_retry_o |-> $past((main_valid_o && main_ready_i) || (walk_valid_o && walk_ready_i)));

  p_main_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (main_valid_o && !main_ready_i) |=> (!main_valid_o || main_retry_i));

  p_walk_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (walk_valid_o && !walk_ready_i) |=> (!walk_valid_o || walk_retry_i));

  p_walk_kind_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_valid_o |-> !walk_final);

  p_main_kind_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (main_valid_o && !main_final_o) |-> !walk_port_en_i);
endmodule

bind ordered_retry_queue orq_checker u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .walk_port_en_i (walk_port_en_i),
  .main_valid_o   (main_valid_o),
  .main_final_o   (main_final_o),
  .main_ready_i   (main_ready_i),
  .main_retry_i   (main_retry_i),
  .walk_valid_o   (walk_valid_o),
  .walk_final     (walk_final),
  .walk_ready_i   (walk_ready_i),
  .walk_retry_i   (walk_retry_i),
  .up_retry_o     (up_retry_o)
);

// File: tb/sim_ordered_retry_queue.sv
module sim_ordered_retry_queue;
  localparam int ID_W  = 4;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_ni = 1'b0, wen = 1'b1, rv = 1'b0, rf = 1'b0;
  logic [ID_W-1:0] rid = '0;
  logic mr = 1'b0, mt = 1'b0, wr = 1'b0, wt = 1'b0;
  logic req_ready, m_v, m_f, w_v, up;
  logic [ID_W-1:0] m_id, w_id;

  ordered_retry_queue #(.ID_W(ID_W), .DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .walk_port_en_i(wen),
    .req_valid_i(rv), .req_final_i(rf), .req_id_i(rid), .req_ready_o(req_ready),
    .main_valid_o(m_v), .main_final_o(m_f), .main_id_o(m_id),
    .main_ready_i(mr), .main_retry_i(mt),
    .walk_valid_o(w_v), .walk_id_o(w_id), .walk_ready_i(wr), .walk_retry_i(wt),
    .up_retry_o(up)
  );

  typedef struct packed {logic fin; logic [ID_W-1:0] id;} ent_t;
  ent_t mq[$], wq[$];
  bit md, wd, exp_up;
  int n_chk = 0, n_fail = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void lane(input int sz, input ent_t h, input bit d, input bit in_v,
                               input ent_t inw, input bit rdy, input bit ret,
                               output bit v, output ent_t o, output bit dir,
                               output bit pop, output bit push, output bit dn);
    bit dr;
    dr   = (d || ret) && sz > 0;
    v    = dr || (sz == 0 && in_v);
    o    = dr ? h : inw;
    dir  = (sz == 0) && in_v && rdy;
    pop  = dr && rdy;
    push = in_v && !dir;
    dn   = pop && sz > 1;
  endfunction

  // evaluate one cycle: inputs already driven after negedge
  task automatic cycle();
    bit to_walk, e_rdy, take, mv, wv, mdir, mpop, mpush, mdn, wdir, wpop, wpush, wdn, trig;
    ent_t mo, wo, mh, wh, inw;
    #1;
    to_walk = wen && !rf;
    e_rdy   = to_walk ? (wq.size() < DEPTH) : (mq.size() < DEPTH);
    take    = rv && e_rdy;
    inw     = '{fin: rf, id: rid};
    mh      = (mq.size() > 0) ? mq[0] : '0;
    wh      = (wq.size() > 0) ? wq[0] : '0;
    lane(mq.size(), mh, md, take && !to_walk, inw, mr, mt, mv, mo, mdir, mpop, mpush, mdn);
    lane(wq.size(), wh, wd, take && to_walk, inw, wr, wt, wv, wo, wdir, wpop, wpush, wdn);
    trig = mdir || (mpop && mh.fin) || wdir;
    chk("R8 req_ready", req_ready, e_rdy);
    chk("R2 R3 R4 R9 main_valid", m_v, mv);
    if (mv) begin
      chk("R4 main_id order", m_id, mo.id);
      chk("R5 main_final", m_f, mo.fin);
    end
    chk("R5 R6 R9 walk_valid", w_v, wv);
    if (wv) chk("R4 R5 walk_id order", w_id, wo.id);
    chk("R7 up_retry", up, exp_up);
    @(posedge clk);
    if (mpop) void'(mq.pop_front());
    if (wpop) void'(wq.pop_front());
    if (mpush) mq.push_back(inw);
    if (wpush) wq.push_back(inw);
    md = mdn;
    wd = wdn;
    exp_up = trig;
  endtask

  task automatic run(int n, int pv, int pf, int pr, int pt);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rv  = ($urandom % 100) < pv;
      rf  = ($urandom % 100) < pf;
      rid = ID_W'($urandom);
      mr  = ($urandom % 100) < pr;
      wr  = ($urandom % 100) < pr;
      mt  = ($urandom % 100) < pt;
      wt  = ($urandom % 100) < pt;
      cycle();
    end
  endtask

  task automatic flush();
    for (int i = 0; i < 3 * DEPTH + 4; i++) begin
      @(negedge clk);
      rv = 1'b0; mr = 1'b1; wr = 1'b1; mt = 1'b1; wt = 1'b1;
      cycle();
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state under reset
    chk("R1 req_ready", req_ready, 1);
    chk("R1 main_valid", m_v, 0);
    chk("R1 walk_valid", w_v, 0);
    chk("R1 up_retry", up, 0);
    rst_ni = 1'b1;
    cycle();
    // walk port fitted
    run(600, 70, 50, 50, 25);
    run(300, 70, 50, 15, 10);
    flush();
    // R9: strobes on empty queues
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      rv = 1'b0; mr = 1'b0; wr = 1'b0; mt = 1'b1; wt = 1'b1;
      #1;
      chk("R9 idle strobe main", m_v, 0);
      chk("R9 idle strobe walk", w_v, 0);
      cycle();
    end
    // walk port absent: fallback routing
    wen = 1'b0;
    run(600, 70, 50, 50, 25);
    run(300, 70, 50, 15, 10);
    flush();
    summary();
  end
endmodule